// File: doc/BRIEF.md
# Synchronous SRAM with Pipelined Deselect

This block is a synthesizable synchronous static RAM with a small parameterized array. It is organised in byte lanes. Every access is a single-cycle command sampled on the rising clock edge. A command is either a read, a write or a deselect. Writes finish in the cycle that issues them. A write can update only the lanes it selects, or it can use a global write strobe that updates the whole word.

Read data leaves the block on one of two paths, and the static `pipe_mode` input picks the path:

- **Bypass path** (`pipe_mode` low): data appears one edge after the command.
- **Registered path** (`pipe_mode` high): data passes through an output register and appears one edge later than on the bypass path.

Deselects and writes travel down the same valid pipeline as reads. In registered mode, the data of a read that precedes a deselect therefore stays on the bus for one more cycle. The outputs turn off only after the second rising edge that follows the deselect.

Output enable and sleep act on the output at once, without waiting for a clock edge. Sleep also blocks every command while the array keeps its contents. The bidirectional data bus is modelled as a separate input port and a separate output port. The output port comes with a valid flag that stands for the bus drivers being on.

Top module: `sram_dcd_top`

## Requirements
- R1: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at the same edge. Every other combination is a deselect: it changes no memory and produces no valid output.
- R2: A selected cycle with `wr_lane_en_n`=0 and `wr_all_n`=1 writes lane i (bits [i*LANE_W +: LANE_W]) only where `lane_sel_n[i]`=0. All other lanes keep their contents.
- R3: A selected cycle with `wr_all_n`=0 writes every lane, whatever `wr_lane_en_n` and `lane_sel_n` hold.
- R4: A selected cycle that is not a write is a read. This includes the case `wr_lane_en_n`=0 with every `lane_sel_n` bit at 1.
- R5: With `pipe_mode`=0, a read sampled at edge n drives its data with `rdata_vld`=1 from edge n until edge n+1.
- R6: With `pipe_mode`=1, a read sampled at edge n drives its data with `rdata_vld`=1 from edge n+1 until edge n+2.
- R7: A deselect or a write sampled at edge n gives `rdata_vld`=0 in the slot where a read would have given data. In registered mode this slot starts after edge n+1, so a read issued just before the deselect stays valid through the following cycle.
- R8: `oe_n`=1 forces `rdata_vld` low and `rdata` to zero at once, without a clock edge.
- R9: `sleep`=1 forces `rdata_vld` low at once and blocks every command, including writes, while the array keeps its contents.
- R10: `rdata` is all zeros whenever `rdata_vld` is 0.
- R11: After reset, and before any read has been issued, `rdata_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address |
| wr_all_n | input | 1 | Global write strobe, active low |
| wr_lane_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| wdata | input | LANES*LANE_W | Write data |
| pipe_mode | input | 1 | 1 selects the registered read path, 0 the bypass path |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power request, active high |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rdata_vld | output | 1 | Output drivers on |

## Verification
The assertions take two things for granted:

- `pipe_mode` is static while commands are in flight.
- The select, address and write inputs are settled at every rising edge.

The timing checks also expect `oe_n` and `sleep` to be sampled at the edge, like every other input. The stimulus follows these rules:

- It changes `pipe_mode` only after several idle cycles with the queue of expected results empty.
- It drives every synchronous input at the falling edge.
- It toggles `oe_n` and `sleep` only in the middle of a cycle, while no scoreboard entry is due.

// File: rtl/sram_dcd_pkg.sv
package sram_dcd_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  // Chip is addressed only for the one legal enable combination.
  function automatic logic chip_hit(input logic a_n, input logic b, input logic c_n);
    return (!a_n) && b && (!c_n);
  endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_dcd_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             sleep,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic             rd_go,
  output logic             wr_go,
  output logic [LANES-1:0] wr_lanes,
  output cmd_e             cmd
);

  logic             hit;
  logic [LANES-1:0] lane_pick;
  logic             lane_wr;

  assign hit       = chip_hit(sel_a_n, sel_b, sel_c_n) && !sleep;
  assign lane_pick = wr_lane_en_n ? '0 : ~lane_sel_n;
  assign lane_wr   = |lane_pick;

  always_comb begin
    cmd = CMD_IDLE;
    if (hit) begin
      if (!wr_all_n || lane_wr) cmd = CMD_WRITE;
      else                      cmd = CMD_READ;
    end
  end

  assign rd_go = (cmd == CMD_READ);
  assign wr_go = (cmd == CMD_WRITE);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane_mask
      assign wr_lanes[g] = wr_go && (!wr_all_n || lane_pick[g]);
    end
  endgenerate

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sel_a_n && sel_b && !sel_c_n) |-> (!rd_go && !wr_go && wr_lanes == '0));

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rd_go && wr_lanes == '0));

  // R3
  gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !wr_all_n) |-> ($countones(wr_lanes) == LANES));

  // R4
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_go && wr_go));

endmodule

// File: rtl/sram_core.sv
module sram_core #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rd_go,
  input  logic [LANES-1:0]          wr_lanes,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
        if (wr_lanes[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk) begin
        if (rd_go) rd_q <= mem[addr];
      end

      assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
  endgenerate

endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic [DW-1:0] core_data,
  input  logic          pipe_mode,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [DW-1:0] rdata,
  output logic          rdata_vld
);

  logic          s1_vld;
  logic          s2_vld;
  logic [DW-1:0] s2_data;
  logic          path_vld;
  logic [DW-1:0] path_data;
  logic          drv_en;

  // Stage 1 follows every command: reads set it, deselects and writes clear it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s1_vld <= rd_go;
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    s2_data <= core_data;
  end

  assign path_vld  = pipe_mode ? s2_vld  : s1_vld;
  assign path_data = pipe_mode ? s2_data : core_data;
  assign drv_en    = !oe_n && !sleep;
  assign rdata_vld = path_vld && drv_en;
  assign rdata     = rdata_vld ? path_data : '0;

  // R7
  dcd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !$past(rd_go, 2)) |-> !rdata_vld);

  // R7
  dcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(rd_go, 2) && !oe_n && !sleep) |-> rdata_vld);

  // R5
  flow_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(rd_go) && !oe_n && !sleep) |-> rdata_vld);

  // R8
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rdata_vld && rdata == '0));

  // R10
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_vld |-> (rdata == '0));

endmodule

// File: rtl/sram_dcd_top.sv
module sram_dcd_top
  import sram_dcd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    pipe_mode,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_vld
);

  localparam int DW = LANES * LANE_W;

  logic             rd_go;
  logic             wr_go;
  logic [LANES-1:0] wr_lanes;
  cmd_e             cmd;
  logic [DW-1:0]    core_data;

  sram_cmd_decode #(.LANES(LANES)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .sel_c_n      (sel_c_n),
    .sleep        (sleep),
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .lane_sel_n   (lane_sel_n),
    .rd_go        (rd_go),
    .wr_go        (wr_go),
    .wr_lanes     (wr_lanes),
    .cmd          (cmd)
  );

  sram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_core (
    .clk      (clk),
    .rd_go    (rd_go),
    .wr_lanes (wr_lanes),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (core_data)
  );

  sram_out_pipe #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_go     (rd_go),
    .core_data (core_data),
    .pipe_mode (pipe_mode),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .rdata     (rdata),
    .rdata_vld (rdata_vld)
  );

  // R7
  wr_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(wr_go)) |-> !rdata_vld);

endmodule

// File: tb/sram_dcd_top_tb.sv
module sram_dcd_top_tb;

  localparam int ADDR_W = 6;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_all_n = 1'b1, wr_lane_en_n = 1'b1;
  logic [LANES-1:0]  lane_sel_n = '1;
  logic [DW-1:0]     wdata = '0;
  logic              pipe_mode = 1'b1;
  logic              oe_n = 1'b0;
  logic              sleep = 1'b0;
  logic [DW-1:0]     rdata;
  logic              rdata_vld;

  sram_dcd_top #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .addr(addr), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
    .lane_sel_n(lane_sel_n), .wdata(wdata), .pipe_mode(pipe_mode), .oe_n(oe_n),
    .sleep(sleep), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  always #2 clk = ~clk;

  typedef struct {
    int            due;
    bit            vld;
    logic [DW-1:0] data;
    string         req;
  } exp_t;

  exp_t          sb_q[$];
  logic [DW-1:0] model [DEPTH];
  int            cyc = 0;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Monitor: compare every due expectation against the ports.
  always @(posedge clk) begin
    #1;
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      exp_t it;
      it = sb_q.pop_front();
      check(rdata_vld == it.vld, it.req, DW'(rdata_vld), DW'(it.vld), "valid");
      check(rdata == (it.vld ? it.data : '0), it.req, rdata,
            it.vld ? it.data : '0, "data");
    end
  end

  // Driver: one command per cycle, with the expected result computed from the requirements.
  task automatic cmd(input logic [2:0] ce, input logic gwn, input logic bwn,
                     input logic [LANES-1:0] bsn, input logic [ADDR_W-1:0] a,
                     input logic [DW-1:0] d, input bit push, input string req);
    bit   hit, wr, rd;
    exp_t it;
    @(negedge clk);
    sel_a_n = ce[0]; sel_b = ce[1]; sel_c_n = ce[2];
    wr_all_n = gwn; wr_lane_en_n = bwn; lane_sel_n = bsn; addr = a; wdata = d;
    hit = !ce[0] && ce[1] && !ce[2] && !sleep;
    wr  = hit && (!gwn || (!bwn && bsn != '1));
    rd  = hit && !wr;
    if (wr) begin
      for (int l = 0; l < LANES; l++)
        if (!gwn || !bsn[l]) model[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
    end
    if (push) begin
      it.due  = cyc + 1 + (pipe_mode ? 1 : 0);
      it.vld  = rd;
      it.data = rd ? model[a] : '0;
      it.req  = req;
      sb_q.push_back(it);
    end
  endtask

  localparam logic [2:0] SEL = 3'b010;

  task automatic rd_cmd(input logic [ADDR_W-1:0] a, input string req);
    cmd(SEL, 1'b1, 1'b1, '1, a, '0, 1'b1, req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cmd(3'b001, 1'b1, 1'b1, '1, '0, '0, 1'b1, req);
  endtask

  task automatic main_seq(input string rdreq);
    for (int i = 0; i < 8; i++)
      cmd(SEL, 1'b0, i[0], 2'(i), 6'(i), DW'(18'h0A5A5 ^ (i * 18'h1357)), 1'b1, "R3");
    for (int i = 0; i < 8; i++) rd_cmd(6'(i), rdreq);
    // read, deselect, read, write, read
    rd_cmd(6'd1, rdreq);
    idle(1, "R7");
    rd_cmd(6'd2, rdreq);
    cmd(SEL, 1'b0, 1'b1, '1, 6'd9, 18'h3C3C3, 1'b1, "R7");
    rd_cmd(6'd9, rdreq);
    // lane write: lane 0 only, then lane 1 only
    cmd(SEL, 1'b1, 1'b0, 2'b10, 6'd3, 18'h2AAAA, 1'b1, "R2");
    rd_cmd(6'd3, "R2");
    cmd(SEL, 1'b1, 1'b0, 2'b01, 6'd4, 18'h15555, 1'b1, "R2");
    rd_cmd(6'd4, "R2");
    // lane-write enable with no lane selected acts as a read
    cmd(SEL, 1'b1, 1'b0, 2'b11, 6'd5, 18'h3FFFF, 1'b1, "R4");
    rd_cmd(6'd5, "R4");
    // every illegal enable combination is a deselect, even with a global write
    for (int c = 0; c < 8; c++)
      if (3'(c) != SEL) cmd(3'(c), 1'b0, 1'b0, 2'b00, 6'd6, 18'h00F0F, 1'b1, "R1");
    rd_cmd(6'd6, "R1");
    idle(4, "R7");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(rdata_vld == 1'b0, "R11", DW'(rdata_vld), '0, "valid in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(rdata_vld == 1'b0 && rdata == '0, "R11", rdata, '0, "after reset");
    // Initialise the locations used by the checks so that no read returns X.
    for (int i = 0; i < 16; i++) cmd(SEL, 1'b0, 1'b1, '1, 6'(i), '0, 1'b0, "");
    idle(3, "R7");

    pipe_mode = 1'b1;
    main_seq("R6");

    @(negedge clk);
    pipe_mode = 1'b0;
    idle(3, "R7");
    main_seq("R5");

    @(negedge clk);
    pipe_mode = 1'b1;
    idle(4, "R7");

    // Output enable acts at once.
    cmd(SEL, 1'b1, 1'b1, '1, 6'd2, '0, 1'b0, "");
    cmd(3'b001, 1'b1, 1'b1, '1, '0, '0, 1'b0, "");
    @(posedge clk);
    #0.5;
    check(rdata_vld == 1'b1 && rdata == model[2], "R6", rdata, model[2], "data before oe");
    oe_n = 1'b1;
    #0.5;
    check(rdata_vld == 1'b0 && rdata == '0, "R8", rdata, '0, "oe high");
    oe_n = 1'b0;
    #0.5;
    check(rdata_vld == 1'b1, "R8", DW'(rdata_vld), 1, "oe low again");
    idle(4, "R7");

    // Sleep acts at once, blocks writes, and the array keeps its contents.
    cmd(SEL, 1'b1, 1'b1, '1, 6'd7, '0, 1'b0, "");
    cmd(3'b001, 1'b1, 1'b1, '1, '0, '0, 1'b0, "");
    @(posedge clk);
    #0.5;
    sleep = 1'b1;
    #0.5;
    check(rdata_vld == 1'b0 && rdata == '0, "R9", rdata, '0, "sleep output");
    cmd(SEL, 1'b0, 1'b1, '1, 6'd7, 18'h12345, 1'b1, "R9");
    rd_cmd(6'd7, "R9");
    idle(3, "R9");
    @(negedge clk);
    sleep = 1'b0;
    rd_cmd(6'd7, "R9");
    idle(4, "R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule